// File: doc/BRIEF.md
# Indirect Bus Access Bridge

This block lets a host that only talks in 64-bit register accesses run single transactions on a downstream bus with 32-bit addresses and a 32-bit data path. The host sees four 64-bit registers: a command word, a reset word, a status word and a data word. Storing a command word launches one downstream transfer as a side effect. Its outcome is left in the status word, and reading the status word clears it.

The host request port is valid/ready. A request is taken on a clock edge where `h_valid` and `h_ready` are both high. The bridge holds `h_ready` low for as long as a downstream transfer is outstanding, so the host must keep its request stable until it is taken. Read data comes back as a single-cycle `h_rvalid` pulse with `h_rdata` one cycle after the read is taken, and there is no back-pressure on that return path. The downstream side is a request/acknowledge master. `d_req` and its fields stay stable until the cycle in which `d_ack` is high. `d_rdata` and `d_err` are sampled in that same cycle.

Top module: `ibridge_top`

## Requirements
- R1: Host byte address bits [4:3] pick the register: 0 is command, 1 is reset, 2 is status and 3 is data. All other address bits are ignored. Reading the command or reset register returns zero.
- R2: Writing the data register stores bits [63:32] of the host word and ignores bits [31:0]. Reading it returns the stored value in bits [63:32], with bits [31:0] zero.
- R3: Reading status returns its current value and clears it to zero in the same access. Status is zero after reset.
- R4: In a command word, bit 48 set means read and clear means write, bits [59:56] give the size in bytes, and bits [31:0] give the downstream address. A command with a size greater than 8 starts no downstream access and leaves status unchanged.
- R5: A successful read loads status with bit 11 set. The downstream byte at the lowest address, taken from `d_rdata[7:0]`, lands in status bits [57:50], and each following byte fills the next lower 8 bits down to bit 26. Bytes beyond the transfer size read as zero.
- R6: A read that ends with `d_err` high loads status with bit 11 set and bits [57:26] all ones.
- R7: A write command drives the stored data word onto `d_wdata` with its most significant byte in lane 0 (`d_wdata[7:0]`, the lowest address). Afterwards status is exactly bit 11, whether `d_err` was high or not.
- R8: While a downstream request is outstanding, `h_ready` is low. `d_req`, `d_write`, `d_addr`, `d_size` and `d_wdata` hold steady until the acknowledge cycle.
- R9: A command with size 0 starts no downstream access and sets status to bit 11 alone.
- R10: Sizes 1 to 4 are passed on `d_size` as given. Sizes 5 to 8 are passed as 4.
- R11: Every accepted host read produces exactly one `h_rvalid` pulse, one cycle after acceptance. No other cycle has `h_rvalid` high.
- R12: Writes to the reset or status registers change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request ready; low while a transfer is outstanding |
| h_write | input | 1 | Host request is a write |
| h_addr | input | HOST_AW | Host byte address |
| h_wdata | input | 64 | Host write data |
| h_rvalid | output | 1 | Read data valid, one cycle after acceptance |
| h_rdata | output | 64 | Read data |
| d_req | output | 1 | Downstream request |
| d_ack | input | 1 | Downstream acknowledge |
| d_write | output | 1 | Downstream write when high, read when low |
| d_addr | output | 32 | Downstream byte address |
| d_size | output | 4 | Downstream byte count, 1 to 4 |
| d_wdata | output | 32 | Downstream write data, lane 0 is the lowest address |
| d_rdata | input | 32 | Downstream read data, lane 0 is the lowest address |
| d_err | input | 1 | Downstream error, valid with d_ack |

## Verification
The hardest cases to reach are the ones where status must not change: a dropped oversized command, or a write aimed at the status register. From the ports these look exactly like a command that did nothing. The stimulus therefore first loads status with a known nonzero pattern by running a read transfer or a size-0 command. It then applies the ignored access, checks that the downstream request count did not move, and reads status expecting the earlier pattern. Stall behaviour is exercised by making the downstream responder wait several cycles before acknowledging, sampling `h_ready` in each of those cycles.

// File: rtl/ibridge_pkg.sv
package ibridge_pkg;

  localparam int HOST_DW      = 64;
  localparam int DS_AW        = 32;
  localparam int DS_DW        = 32;
  localparam int SZ_W         = 4;
  localparam int LANES        = DS_DW / 8;
  localparam int MAX_SIZE     = 8;

  localparam int CMD_RD_BIT   = 48;
  localparam int CMD_SZ_LSB   = 56;
  localparam int ST_DONE_BIT  = 11;
  localparam int ST_WORD_LSB  = 26;
  localparam int DATA_LSB     = HOST_DW - DS_DW;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_RST  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             rd;
    logic [SZ_W-1:0]  size;
    logic [DS_AW-1:0] addr;
  } cmd_t;

  function automatic logic [HOST_DW-1:0] status_word(input logic [DS_DW-1:0] w);
    logic [HOST_DW-1:0] s;
    s = '0;
    s[ST_DONE_BIT] = 1'b1;
    s[ST_WORD_LSB +: DS_DW] = w;
    return s;
  endfunction

endpackage

// File: rtl/ibridge_cmd.sv
module ibridge_cmd
  import ibridge_pkg::*;
(
  input  logic [HOST_DW-1:0] word,
  output cmd_t               cmd,
  output logic               legal,
  output logic               noop,
  output logic [SZ_W-1:0]    lanes
);

  always_comb begin
    cmd.rd   = word[CMD_RD_BIT];
    cmd.size = word[CMD_SZ_LSB +: SZ_W];
    cmd.addr = word[DS_AW-1:0];
    legal    = (cmd.size <= SZ_W'(MAX_SIZE));
    noop     = (cmd.size == '0);
    lanes    = (cmd.size > SZ_W'(LANES)) ? SZ_W'(LANES) : cmd.size;
  end

endmodule

// File: rtl/ibridge_xfer.sv
module ibridge_xfer
  import ibridge_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  cmd_t             cmd,
  input  logic [SZ_W-1:0]  lanes,
  input  logic [DS_DW-1:0] wword,
  output logic             d_req,
  input  logic             d_ack,
  output logic             d_write,
  output logic [DS_AW-1:0] d_addr,
  output logic [SZ_W-1:0]  d_size,
  output logic [DS_DW-1:0] d_wdata,
  input  logic [DS_DW-1:0] d_rdata,
  input  logic             d_err,
  output logic             busy,
  output logic             done,
  output logic             done_rd,
  output logic             done_err,
  output logic [DS_DW-1:0] done_word
);

  logic             req_q;
  logic             wr_q;
  logic [DS_AW-1:0] addr_q;
  logic [SZ_W-1:0]  size_q;
  logic [DS_DW-1:0] wdata_q;
  logic [DS_DW-1:0] swapped;
  logic [DS_DW-1:0] packed_rd;

  // most significant byte of the data word goes to the lowest address lane
  for (genvar i = 0; i < LANES; i++) begin : g_wlane
    assign swapped[8*i +: 8] = wword[DS_DW-1-8*i -: 8];
  end

  // lowest address lane goes to the top of the status field; unused lanes zero
  for (genvar i = 0; i < LANES; i++) begin : g_rlane
    assign packed_rd[DS_DW-1-8*i -: 8] =
      (SZ_W'(i) < size_q) ? d_rdata[8*i +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
    end else if (start && !req_q) begin
      req_q   <= 1'b1;
      wr_q    <= !cmd.rd;
      addr_q  <= cmd.addr;
      size_q  <= lanes;
      wdata_q <= swapped;
    end else if (req_q && d_ack) begin
      req_q   <= 1'b0;
    end
  end

  assign d_req     = req_q;
  assign d_write   = wr_q;
  assign d_addr    = addr_q;
  assign d_size    = size_q;
  assign d_wdata   = wdata_q;
  assign busy      = req_q;
  assign done      = req_q && d_ack;
  assign done_rd   = !wr_q;
  assign done_err  = d_err;
  assign done_word = d_err ? '1 : packed_rd;

endmodule

// File: rtl/ibridge_regs.sv
module ibridge_regs
  import ibridge_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc,
  input  logic               wr,
  input  reg_sel_e           sel,
  input  logic [HOST_DW-1:0] wdata,
  input  logic               cmd_legal,
  input  logic               cmd_noop,
  input  logic               xfer_done,
  input  logic               xfer_rd,
  input  logic [DS_DW-1:0]   xfer_word,
  output logic               start,
  output logic [DS_DW-1:0]   data_q,
  output logic               rvalid,
  output logic [HOST_DW-1:0] rdata
);

  logic [HOST_DW-1:0] stat_q;
  logic               cmd_wr;
  logic               stat_rd;
  logic [HOST_DW-1:0] rd_mux;

  assign cmd_wr  = acc && wr && (sel == SEL_CMD) && cmd_legal;
  assign start   = cmd_wr && !cmd_noop;
  assign stat_rd = acc && !wr && (sel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (acc && wr && (sel == SEL_DATA)) begin
      data_q <= wdata[DATA_LSB +: DS_DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (xfer_done) begin
      stat_q <= xfer_rd ? status_word(xfer_word) : status_word('0);
    end else if (cmd_wr && cmd_noop) begin
      stat_q <= status_word('0);
    end else if (stat_rd) begin
      stat_q <= '0;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_mux = stat_q;
      SEL_DATA: rd_mux = {data_q, {DATA_LSB{1'b0}}};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= acc && !wr;
      if (acc && !wr) rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/ibridge_top.sv
module ibridge_top
  import ibridge_pkg::*;
#(
  parameter int HOST_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_valid,
  output logic               h_ready,
  input  logic               h_write,
  input  logic [HOST_AW-1:0] h_addr,
  input  logic [63:0]        h_wdata,
  output logic               h_rvalid,
  output logic [63:0]        h_rdata,
  output logic               d_req,
  input  logic               d_ack,
  output logic               d_write,
  output logic [31:0]        d_addr,
  output logic [3:0]         d_size,
  output logic [31:0]        d_wdata,
  input  logic [31:0]        d_rdata,
  input  logic               d_err
);

  cmd_t             cmd;
  logic             cmd_legal;
  logic             cmd_noop;
  logic [SZ_W-1:0]  lanes;
  logic             busy;
  logic             acc;
  logic             start;
  logic [DS_DW-1:0] data_q;
  logic             xfer_done;
  logic             xfer_rd;
  logic             xfer_err;
  logic [DS_DW-1:0] xfer_word;
  reg_sel_e         sel;

  assign h_ready = !busy;
  assign acc     = h_valid && h_ready;
  assign sel     = reg_sel_e'(h_addr[4:3]);

  ibridge_cmd u_cmd (
    .word  (h_wdata),
    .cmd   (cmd),
    .legal (cmd_legal),
    .noop  (cmd_noop),
    .lanes (lanes)
  );

  ibridge_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .wr        (h_write),
    .sel       (sel),
    .wdata     (h_wdata),
    .cmd_legal (cmd_legal),
    .cmd_noop  (cmd_noop),
    .xfer_done (xfer_done),
    .xfer_rd   (xfer_rd),
    .xfer_word (xfer_word),
    .start     (start),
    .data_q    (data_q),
    .rvalid    (h_rvalid),
    .rdata     (h_rdata)
  );

  ibridge_xfer u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd       (cmd),
    .lanes     (lanes),
    .wword     (data_q),
    .d_req     (d_req),
    .d_ack     (d_ack),
    .d_write   (d_write),
    .d_addr    (d_addr),
    .d_size    (d_size),
    .d_wdata   (d_wdata),
    .d_rdata   (d_rdata),
    .d_err     (d_err),
    .busy      (busy),
    .done      (xfer_done),
    .done_rd   (xfer_rd),
    .done_err  (xfer_err),
    .done_word (xfer_word)
  );

endmodule

// File: rtl/ibridge_checker.sv
module ibridge_checker #(
  parameter int HOST_AW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               h_valid,
  input logic               h_ready,
  input logic               h_write,
  input logic [HOST_AW-1:0] h_addr,
  input logic [63:0]        h_wdata,
  input logic               h_rvalid,
  input logic [63:0]        h_rdata,
  input logic               d_req,
  input logic               d_ack,
  input logic               d_write,
  input logic [31:0]        d_addr,
  input logic [3:0]         d_size,
  input logic [31:0]        d_wdata
);

  logic rd_acc;
  logic cmd_acc;
  assign rd_acc  = h_valid && h_ready && !h_write;
  assign cmd_acc = h_valid && h_ready && h_write && (h_addr[4:3] == 2'd0);

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    d_req |-> !h_ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_ack) |=> (d_req && $stable(d_addr) && $stable(d_size)
                           && $stable(d_write) && $stable(d_wdata)));

  assert_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> h_rvalid);

  assert_norsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !h_rvalid);

  assert_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !h_addr[4]) |=> (h_rdata == 64'd0));

  assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && (h_wdata[59:56] > 4'd8)) |=> !d_req);

  assert_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && (h_wdata[59:56] == 4'd0)) |=> !d_req);

  assert_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
    d_req |-> (d_size >= 4'd1 && d_size <= 4'd4));

endmodule

bind ibridge_top ibridge_checker #(.HOST_AW(HOST_AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .h_valid  (h_valid),
  .h_ready  (h_ready),
  .h_write  (h_write),
  .h_addr   (h_addr),
  .h_wdata  (h_wdata),
  .h_rvalid (h_rvalid),
  .h_rdata  (h_rdata),
  .d_req    (d_req),
  .d_ack    (d_ack),
  .d_write  (d_write),
  .d_addr   (d_addr),
  .d_size   (d_size),
  .d_wdata  (d_wdata)
);

// File: tb/ibridge_top_bench.sv
module ibridge_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_valid = 1'b0;
  logic        h_ready;
  logic        h_write = 1'b0;
  logic [7:0]  h_addr = '0;
  logic [63:0] h_wdata = '0;
  logic        h_rvalid;
  logic [63:0] h_rdata;
  logic        d_req;
  logic        d_ack = 1'b0;
  logic        d_write;
  logic [31:0] d_addr;
  logic [3:0]  d_size;
  logic [31:0] d_wdata;
  logic [31:0] d_rdata = '0;
  logic        d_err = 1'b0;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit ended   = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  int          lat = 0;
  logic [31:0] rsp_data = '0;
  logic        rsp_err = 1'b0;
  int          ds_cnt = 0;
  logic [31:0] seen_addr, seen_wdata;
  logic [3:0]  seen_size;
  logic        seen_write;

  localparam logic [63:0] DONE = 64'h800;

  ibridge_top u_ibridge_top (.*);

  always #5 clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host(bit wr, logic [7:0] a, logic [63:0] d);
    @(negedge clk);
    while (!h_ready) @(negedge clk);
    h_valid = 1'b1; h_write = wr; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_valid = 1'b0;
  endtask

  task automatic hwrite(logic [7:0] a, logic [63:0] d);
    host(1'b1, a, d);
  endtask

  task automatic hread(logic [7:0] a, logic [63:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    host(1'b0, a, 64'd0);
  endtask

  function automatic logic [63:0] cmdw(bit rd, logic [3:0] sz, logic [31:0] a);
    logic [63:0] w;
    w = 64'd0;
    w[48] = rd;
    w[59:56] = sz;
    w[31:0] = a;
    return w;
  endfunction

  // monitor: compare read responses against the scoreboard
  always @(negedge clk) begin
    if (rst_n && h_rvalid) begin
      if (exp_q.size() == 0) begin
        vectors++; fails++;
        $display("FAIL R11 unexpected response actual=%h expected=none", h_rdata);
      end else begin
        check(tag_q.pop_front(), h_rdata, exp_q.pop_front());
      end
    end
  end

  // downstream responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && d_req) begin
        for (int k = 0; k < lat; k++) begin
          check("R8 ready low while outstanding", {63'd0, h_ready}, 64'd0);
          @(negedge clk);
        end
        seen_addr = d_addr; seen_wdata = d_wdata;
        seen_size = d_size; seen_write = d_write;
        ds_cnt++;
        d_ack = 1'b1; d_rdata = rsp_data; d_err = rsp_err;
        @(negedge clk);
        d_ack = 1'b0; d_err = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !ended) begin
      ended = 1;
      vectors++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset ready", {63'd0, h_ready}, 64'd1);
    check("R8 reset no request", {63'd0, d_req}, 64'd0);
    hread(8'h10, 64'd0, "R3 status zero after reset");

    // R2: data register keeps upper half only
    hwrite(8'h18, 64'hA1B2C3D4_DEADBEEF);
    hread(8'h18, 64'hA1B2C3D4_00000000, "R2 data readback");
    // R1: address decode ignores other bits; cmd/reset read zero
    hread(8'hF8, 64'hA1B2C3D4_00000000, "R1 decode alias of data");
    hread(8'h00, 64'd0, "R1 command reads zero");
    hread(8'h08, 64'd0, "R1 reset reads zero");

    // R7: write transfer, byte order and status
    lat = 2;
    hwrite(8'h00, cmdw(0, 4'd4, 32'h0000_1234));
    hread(8'h10, DONE, "R7 write status");
    check("R7 write lanes", {32'd0, seen_wdata}, {32'd0, 32'hD4C3B2A1});
    check("R7 write addr", {32'd0, seen_addr}, 64'h1234);
    check("R7 write dir", {63'd0, seen_write}, 64'd1);
    hread(8'h10, 64'd0, "R3 status cleared by read");

    // R7: failed write still reports done alone
    rsp_err = 1'b1; lat = 0;
    hwrite(8'h00, cmdw(0, 4'd2, 32'h10));
    rsp_err = 1'b0;
    hread(8'h10, DONE, "R7 failed write status");

    // R5: read success, full word
    rsp_data = 32'h44332211; lat = 3;
    hwrite(8'h00, cmdw(1, 4'd4, 32'hCAFE_0000));
    hread(8'h10, DONE | (64'h11223344 << 26), "R5 read 4 bytes");
    check("R5 read addr", {32'd0, seen_addr}, 64'hCAFE_0000);
    check("R5 read dir", {63'd0, seen_write}, 64'd0);

    // R5: short read zero-fills
    lat = 0;
    hwrite(8'h00, cmdw(1, 4'd2, 32'h20));
    hread(8'h10, DONE | (64'h11220000 << 26), "R5 read 2 bytes");
    check("R10 size 2 passed", {60'd0, seen_size}, 64'd2);

    // R10: size 8 capped to 4
    hwrite(8'h00, cmdw(1, 4'd8, 32'h30));
    hread(8'h10, DONE | (64'h11223344 << 26), "R10 read size 8");
    check("R10 size 8 capped", {60'd0, seen_size}, 64'd4);

    // R6: failed read
    rsp_err = 1'b1;
    hwrite(8'h00, cmdw(1, 4'd4, 32'h40));
    rsp_err = 1'b0;
    hread(8'h10, DONE | (64'hFFFFFFFF << 26), "R6 failed read");

    // R9 then R4: noop sets done, oversized command leaves it alone
    base = ds_cnt;
    hwrite(8'h00, cmdw(1, 4'd0, 32'h50));
    hwrite(8'h00, cmdw(1, 4'd9, 32'h60));
    hwrite(8'h00, cmdw(0, 4'd15, 32'h70));
    repeat (3) @(negedge clk);
    check("R9 R4 no downstream access", 64'(ds_cnt - base), 64'd0);
    hread(8'h10, DONE, "R9 noop done / R4 status kept");

    // R12: writes to reset/status change nothing
    hwrite(8'h00, cmdw(1, 4'd4, 32'h80));
    hwrite(8'h10, 64'hFFFF_FFFF_FFFF_FFFF);
    hwrite(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
    hread(8'h10, DONE | (64'h11223344 << 26), "R12 status after ignored writes");
    hread(8'h18, 64'hA1B2C3D4_00000000, "R12 data after ignored writes");

    repeat (5) @(negedge clk);
    check("R11 all responses seen", 64'(exp_q.size()), 64'd0);
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule